// File: doc/BRIEF.md
# Shared Interrupt Affinity Router

This block holds one 64-bit routing register for each shared interrupt. Software writes a target affinity into it. The block keeps that value so it can be read back exactly as written, and resolves it to a single target CPU. The affinity has three 8-bit levels and is held compressed in the low word. Resolution compares the written affinity, in parallel, against a table of the affinity values of the CPUs that are present.

The block keeps one target bitmap per CPU, with one bit per shared interrupt. When a routing register is written, the interrupt's bit is removed from the bitmap of the CPU it was routed to before, if there was one. The bit is then set in the bitmap of the newly matched CPU. An affinity that matches no present CPU leaves the interrupt with no target. Its resolved index then holds a not-allocated code (all ones in an 8-bit index), so the interrupt can still become pending elsewhere but is delivered nowhere.

The register window is addressed in 32-bit words. Shared interrupt 32 is the first entry, at word 64. Entry n has its low word at word 2n and its high word at word 2n+1.

Top module: `spi_aff_router`

## Requirements
- R1: While reset is held and after it is released, every shared interrupt targets CPU 0 only, and reading any low routing word returns CPU 0's table affinity.
- R2: Every high routing word (odd word address inside the window) reads as zero, and writes to it change neither the stored affinity nor any target bit.
- R3: A read of a low routing word returns level 0 in bits [7:0], level 1 in [15:8] and level 2 in [23:16], with bits [31:24] zero whatever was written there. Read data is registered and valid in the cycle after the read strobe; it is zero in the cycle after a cycle with no read.
- R4: A write to a low routing word moves the interrupt's target bit to the matched CPU. The new bitmap is visible after the second rising edge that follows the write cycle. The bit for CPU c and interrupt index s is output bit c*NUM_SPI+s, where s is the interrupt number minus 32.
- R5: Each shared interrupt has its bit set in at most one CPU's bitmap at any time.
- R6: A written affinity that matches no present CPU clears every target bit of that interrupt. The written value is still returned on read.
- R7: Only entries whose present bit is set take part in the match. When several present entries match, the lowest CPU index wins.
- R8: Word addresses below 64 or at or above 64+2*NUM_SPI read as zero, and writes to them have no effect.
- R9: Writing a matching affinity to an interrupt that has no target sets exactly the new CPU's bit.
- R10: Routing is resolved only when a routing register is written; later changes to the CPU affinity table do not move existing targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address inside the routing window space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_present | input | NUM_CPU | One bit per CPU table entry that exists |
| cpu_aff | input | NUM_CPU*24 | Affinity of each CPU; entry c in bits [c*24 +: 24] |
| tgt_map | output | NUM_CPU*NUM_SPI | Per-CPU target bitmaps; CPU c in bits [c*NUM_SPI +: NUM_SPI] |

## Verification
The assertions assume that the CPU affinity table is stable between a write's first and second edge. They also assume it holds no present entry at an index of NUM_CPU or above, and that CPU 0's entry is valid while reset is asserted. The stimulus changes the table and the present bits only while no routing write is in flight. It loads CPU 0's affinity before reset and keeps it unchanged, so the reset state is well defined. Duplicate affinities, absent entries, unmatched values and table changes after a write are all applied within these limits, and each is followed by enough idle cycles for the update to settle.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int LVL_W = 8;
  localparam int NUM_LVL = 3;
  localparam int AFF_W = LVL_W * NUM_LVL;
  localparam int IDX_W = 8;
  localparam logic [IDX_W-1:0] NOT_ALLOC = '1;

  typedef logic [AFF_W-1:0] aff_t;
  typedef logic [IDX_W-1:0] cpu_idx_t;

  // Expand a compressed affinity into the low routing word layout.
  function automatic logic [31:0] expand_low(aff_t a);
    return {{(32-AFF_W){1'b0}}, a};
  endfunction
endpackage

// File: rtl/aff_match.sv
module aff_match
  import router_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  aff_t                     aff,
  input  logic [NUM_CPU*AFF_W-1:0] cpu_aff,
  input  logic [NUM_CPU-1:0]       cpu_present,
  output logic                     hit,
  output cpu_idx_t                 idx
);
  logic [NUM_CPU-1:0] eq;

  genvar c;
  generate
    for (c = 0; c < NUM_CPU; c++) begin : g_cmp
      assign eq[c] = cpu_present[c] && (cpu_aff[c*AFF_W +: AFF_W] == aff);
    end
  endgenerate

  // The lowest matching index has priority.
  always_comb begin
    hit = 1'b0;
    idx = NOT_ALLOC;
    for (int i = NUM_CPU - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = cpu_idx_t'(i);
      end
    end
  end
endmodule

// File: rtl/route_store.sv
module route_store
  import router_pkg::*;
#(
  parameter int NUM_SPI = 32,
  localparam int SPI_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  aff_t             rst_aff,
  input  logic             we,
  input  logic [SPI_W-1:0] wspi,
  input  aff_t             wdata,
  input  logic             re,
  input  logic [SPI_W-1:0] rspi,
  output logic [31:0]      rdata
);
  aff_t mem [NUM_SPI];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SPI; s++) mem[s] <= rst_aff;
    end else if (we) begin
      mem[wspi] <= wdata;
    end
  end

  // Read-before-write, registered output.
  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (re)  rdata <= expand_low(mem[rspi]);
    else          rdata <= '0;
  end
endmodule

// File: rtl/target_map.sv
module target_map
  import router_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int NUM_CPU = 4,
  localparam int SPI_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1,
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic [SPI_W-1:0]         spi,
  input  aff_t                     aff,
  input  logic [NUM_CPU*AFF_W-1:0] cpu_aff,
  input  logic [NUM_CPU-1:0]       cpu_present,
  output logic [NUM_CPU-1:0][NUM_SPI-1:0] map_q
);
  logic     hit;
  cpu_idx_t new_idx;
  cpu_idx_t old_idx;
  cpu_idx_t idx_q [NUM_SPI];
  logic [NUM_CPU-1:0][NUM_SPI-1:0] map_d;
  logic [NUM_SPI-1:0][NUM_CPU-1:0] col;

  aff_match #(.NUM_CPU(NUM_CPU)) u_match (
    .aff(aff), .cpu_aff(cpu_aff), .cpu_present(cpu_present),
    .hit(hit), .idx(new_idx)
  );

  assign old_idx = idx_q[spi];

  always_comb begin
    map_d = map_q;
    if (upd) begin
      if (old_idx != NOT_ALLOC) map_d[old_idx[CW-1:0]][spi] = 1'b0;
      if (hit) map_d[new_idx[CW-1:0]][spi] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CPU; c++) map_q[c] <= (c == 0) ? '1 : '0;
      for (int s = 0; s < NUM_SPI; s++) idx_q[s] <= '0;
    end else begin
      map_q <= map_d;
      if (upd) idx_q[spi] <= hit ? new_idx : NOT_ALLOC;
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SPI; s++)
      for (int c = 0; c < NUM_CPU; c++)
        col[s][c] = map_q[c][s];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SPI; g++) begin : g_chk
      a_r5_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col[g]));
    end
  endgenerate

  a_r4_new_bit_set: assert property (@(posedge clk) disable iff (rst)
    (upd && hit) |=> map_q[$past(new_idx[CW-1:0])][$past(spi)]);

  a_r6_no_target: assert property (@(posedge clk) disable iff (rst)
    (upd && !hit) |=> (col[$past(spi)] == '0));
endmodule

// File: rtl/spi_aff_router.sv
module spi_aff_router
  import router_pkg::*;
#(
  parameter int NUM_SPI = 32,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W = 10,
  parameter int FIRST_ID = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_CPU-1:0]         cpu_present,
  input  logic [NUM_CPU*24-1:0]      cpu_aff,
  output logic [NUM_CPU*NUM_SPI-1:0] tgt_map
);
  localparam int SPI_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(2 * FIRST_ID);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(2 * (FIRST_ID + NUM_SPI));

  logic              in_win;
  logic [ADDR_W-1:0] off;
  logic [SPI_W-1:0]  spi;
  logic              hi_word;
  logic              wr_low;
  logic              s1_vld;
  logic [SPI_W-1:0]  s1_spi;
  aff_t              s1_aff;
  logic [NUM_CPU-1:0][NUM_SPI-1:0] map_q;

  assign in_win  = (reg_addr >= WIN_LO) && (reg_addr < WIN_HI);
  assign off     = reg_addr - WIN_LO;
  assign spi     = off[SPI_W:1];
  assign hi_word = off[0];
  assign wr_low  = reg_wr && in_win && !hi_word;

  // Stage 1: capture the write for the lookup in the next cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_spi <= '0;
      s1_aff <= '0;
    end else begin
      s1_vld <= wr_low;
      s1_spi <= spi;
      s1_aff <= reg_wdata[AFF_W-1:0];
    end
  end

  route_store #(.NUM_SPI(NUM_SPI)) u_store (
    .clk(clk), .rst(rst), .rst_aff(cpu_aff[AFF_W-1:0]),
    .we(wr_low), .wspi(spi), .wdata(reg_wdata[AFF_W-1:0]),
    .re(reg_rd && in_win && !hi_word), .rspi(spi), .rdata(reg_rdata)
  );

  target_map #(.NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU)) u_map (
    .clk(clk), .rst(rst), .upd(s1_vld), .spi(s1_spi), .aff(s1_aff),
    .cpu_aff(cpu_aff), .cpu_present(cpu_present), .map_q(map_q)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CPU; c++) begin : g_out
      assign tgt_map[c*NUM_SPI +: NUM_SPI] = map_q[c];
    end
  endgenerate

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && in_win && hi_word) |=> (reg_rdata == 32'h0));

  a_r8_outside_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !in_win) |=> (reg_rdata == 32'h0));

  a_r3_top_byte_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (reg_rdata[31:24] == 8'h0));
endmodule

// File: tb/spi_aff_router_tb.sv
module spi_aff_router_tb;
  localparam int NS = 32;
  localparam int NC = 4;
  localparam int AW = 10;
  localparam int BASE = 64;

  logic clk = 0;
  logic rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC-1:0] cpu_present;
  logic [NC*24-1:0] cpu_aff;
  logic [NC*NS-1:0] tgt_map;
  logic [23:0] c_aff [NC];

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb for (int c = 0; c < NC; c++) cpu_aff[c*24 +: 24] = c_aff[c];

  spi_aff_router #(.NUM_SPI(NS), .NUM_CPU(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_present(cpu_present), .cpu_aff(cpu_aff), .tgt_map(tgt_map)
  );

  // Behavioural reference model.
  int m_aff [NS];
  int m_cpu [NS];
  logic [NC*NS-1:0] m_map;
  logic [31:0] m_rdata;
  bit p_vld;
  int p_spi, p_aff;

  function automatic int find_cpu(int a);
    for (int c = 0; c < NC; c++)
      if (cpu_present[c] && int'(c_aff[c]) == a) return c;
    return -1;
  endfunction

  always @(posedge clk) begin
    int a, s;
    bit win;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_aff[i] = int'(c_aff[0]); m_cpu[i] = 0; end
      m_map = '0;
      m_map[NS-1:0] = '1;
      m_rdata = 0;
      p_vld = 0;
    end else begin
      if (p_vld) begin
        if (m_cpu[p_spi] >= 0) m_map[m_cpu[p_spi]*NS + p_spi] = 1'b0;
        m_cpu[p_spi] = find_cpu(p_aff);
        if (m_cpu[p_spi] >= 0) m_map[m_cpu[p_spi]*NS + p_spi] = 1'b1;
      end
      a = int'(reg_addr);
      win = (a >= BASE) && (a < BASE + 2*NS);
      s = (a - BASE) / 2;
      m_rdata = 0;
      if (reg_rd && win && (a % 2 == 0)) m_rdata = {8'h0, m_aff[s][23:0]};
      p_vld = reg_wr && win && (a % 2 == 0);
      if (p_vld) begin
        p_spi = s;
        p_aff = int'(reg_wdata[23:0]);
        m_aff[s] = p_aff;
      end
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 map", 128'(tgt_map), 128'(m_map));
      chk("R3 rdata", 128'(reg_rdata), 128'(m_rdata));
    end
  end

  task automatic wr_reg(int addr, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = AW'(addr); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(int addr, output logic [31:0] q);
    @(negedge clk); reg_rd = 1; reg_addr = AW'(addr);
    @(negedge clk); reg_rd = 0; q = reg_rdata;
  endtask

  function automatic logic [NC-1:0] column(int s);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = tgt_map[c*NS + s];
    return v;
  endfunction

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    logic [NC*NS-1:0] snap;
    c_aff[0] = 24'h000100; c_aff[1] = 24'h000101;
    c_aff[2] = 24'h010200; c_aff[3] = 24'h020300;
    cpu_present = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset map", 128'(tgt_map), 128'({{(NC*NS-NS){1'b0}}, {NS{1'b1}}}));
    rd_reg(BASE + 2*5, q);
    chk("R1 reset readback", 128'(q), 128'(32'h000100));
    // R4 move spi 3 to cpu 2, top byte dropped (R3)
    wr_reg(BASE + 2*3, 32'hFF010200);
    @(negedge clk);
    chk("R4 spi3 column", 128'(column(3)), 128'(4'b0100));
    rd_reg(BASE + 2*3, q);
    chk("R3 layout", 128'(q), 128'(32'h00010200));
    // R2 high word
    wr_reg(BASE + 2*3 + 1, 32'h00020300);
    @(negedge clk);
    chk("R2 no move", 128'(column(3)), 128'(4'b0100));
    rd_reg(BASE + 2*3 + 1, q);
    chk("R2 high reads zero", 128'(q), 128'(0));
    rd_reg(BASE + 2*3, q);
    chk("R2 low kept", 128'(q), 128'(32'h00010200));
    // R6 unmatched
    wr_reg(BASE + 2*7, 32'h00ABCDEF);
    @(negedge clk);
    chk("R6 no target", 128'(column(7)), 128'(0));
    rd_reg(BASE + 2*7, q);
    chk("R6 read as written", 128'(q), 128'(32'h00ABCDEF));
    // R9 from none to cpu 3
    wr_reg(BASE + 2*7, 32'h00020300);
    @(negedge clk);
    chk("R9 new bit only", 128'(column(7)), 128'(4'b1000));
    // R7 absent entry ignored
    @(negedge clk); cpu_present[1] = 1'b0;
    wr_reg(BASE + 2*9, 32'h00000101);
    @(negedge clk);
    chk("R7 absent ignored", 128'(column(9)), 128'(0));
    cpu_present[1] = 1'b1;
    // R7 duplicates: lowest index wins
    @(negedge clk); c_aff[3] = 24'h010200;
    wr_reg(BASE + 2*10, 32'h00010200);
    @(negedge clk);
    chk("R7 lowest wins", 128'(column(10)), 128'(4'b0100));
    // R10 table change after write
    @(negedge clk); c_aff[2] = 24'h030000; c_aff[3] = 24'h020300;
    repeat (3) @(negedge clk);
    chk("R10 targets kept", 128'(column(10)), 128'(4'b0100));
    c_aff[2] = 24'h010200;
    // R8 outside window
    snap = tgt_map;
    wr_reg(10, 32'h00010200);
    wr_reg(BASE + 2*NS, 32'h00010200);
    @(negedge clk);
    chk("R8 write ignored", 128'(tgt_map), 128'(snap));
    rd_reg(10, q);
    chk("R8 low read zero", 128'(q), 128'(0));
    rd_reg(BASE + 2*NS, q);
    chk("R8 high read zero", 128'(q), 128'(0));
    // R4 back-to-back writes to the same interrupt
    wr_reg(BASE + 2*12, 32'h00000101);
    wr_reg(BASE + 2*12, 32'h00020300);
    @(negedge clk);
    chk("R4 back to back", 128'(column(12)), 128'(4'b1000));
    // Sweep: each interrupt to cpu (s mod NC)
    for (int s = 0; s < NS; s++) wr_reg(BASE + 2*s, {8'h0, c_aff[s % NC]});
    repeat (2) @(negedge clk);
    for (int s = 0; s < NS; s++) begin
      chk("R5 one target", 128'($countones(column(s))), 128'(1));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule